// File: doc/BRIEF.md
# CAN Acknowledge Slot Mode Controller

This block sits beside a CAN frame sequencer and owns the tail of every frame: the CRC delimiter, the acknowledge slot, the acknowledge delimiter and the entry into end of frame. From the current field code, the two bit-timing strobes, the sampled bus level and the node's role, it decides which level the node puts on the bus and which level the node's own receive path sees. It also judges whether the frame succeeded and keeps one count of good transmitted frames and one of good received frames.

Three operating modes change how the acknowledge is handled. In self-test a transmitter accepts a recessive acknowledge slot as success. In acknowledge-forbidden a receiver withholds its dominant acknowledge. In listen-only the node never drives dominant, yet a receiver with a good CRC feeds a dominant acknowledge into its own receive path so that it still sees the frame as acknowledged. The sequencer supplies the frame bits before the CRC delimiter through `seq_bit`; bit timing, CRC and stuffing are done elsewhere.

Top module: `ack_slot_ctrl`

## Requirements
- R1: After synchronous reset `tx_bit` and `rx_bit` are 1 (recessive), `ack_err` is 0 and both frame counters are 0.
- R2: `tx_bit` only changes in the clock after a cycle with `sync_strobe` high; it then takes the level chosen for the current field. In the body field (code 1) that level is `seq_bit`, so a dominant last CRC bit is still on `tx_bit` after the field moves to the CRC delimiter (code 2) until the next sync strobe.
- R3: A receiver (`is_tx`=0) in normal mode with `crc_ok`=1 drives 0 for a sync strobe in the acknowledge field (code 3) and 1 again for the sync strobe in the acknowledge delimiter (code 4); CRC delimiter, acknowledge delimiter, end of frame (code 5) and idle (code 0) drive 1.
- R4: With `md_ack_forbid`=1 a receiver keeps `tx_bit` at 1 through the CRC delimiter, acknowledge and acknowledge delimiter.
- R5: With `md_listen`=1 every sync strobe loads 1 into `tx_bit`, in every field.
- R6: `rx_bit` takes `bus_bit` in the clock after a `sp_strobe`, except that a listen-only receiver with `crc_ok`=1 takes 0 at the sample in the acknowledge field whatever the bus level.
- R7: A transmitter not in self-test that samples 1 in the acknowledge field raises `ack_err` for exactly one clock, the clock after that sample, and that frame is not counted.
- R8: A transmitter in self-test never raises `ack_err`, and its frame counts as good whatever the acknowledge level.
- R9: `tx_frames` rises by one in the clock after the field enters end of frame when the latched outcome is a good transmitted frame (dominant acknowledge, or self-test).
- R10: `rx_frames` rises by one in the clock after the field enters end of frame for a receiver whose `crc_ok` was 1 at the acknowledge sample, in normal, acknowledge-forbidden and listen-only modes alike; a receiver with `crc_ok`=0 is not counted.
- R11: Counters change only once per frame: holding end of frame for several bits or passing through idle adds nothing more; they are `CNT_W` bits and wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| field | input | 3 | Field code: 0 idle, 1 body, 2 CRC delimiter, 3 acknowledge, 4 acknowledge delimiter, 5 end of frame |
| sp_strobe | input | 1 | Sample point strobe, one clock |
| sync_strobe | input | 1 | Sync segment strobe, one clock |
| bus_bit | input | 1 | Bus level at the sample point (0 dominant) |
| seq_bit | input | 1 | Bit the sequencer wants to send in the body field |
| is_tx | input | 1 | Node is transmitter of the current frame |
| crc_ok | input | 1 | Received CRC was valid |
| md_self_test | input | 1 | Self-test mode |
| md_ack_forbid | input | 1 | Acknowledge-forbidden mode |
| md_listen | input | 1 | Listen-only mode |
| tx_bit | output | 1 | Level driven to the transceiver |
| rx_bit | output | 1 | Level seen by the internal receive path |
| ack_err | output | 1 | Missing acknowledge, one-clock pulse |
| tx_frames | output | CNT_W | Good transmitted frames |
| rx_frames | output | CNT_W | Good received frames |

## Verification
The sync segment update of the driven level and the sample point capture can land in the same clock; random frames sometimes raise both strobes together in every field, including the acknowledge slot where the acknowledge judgement is also taken. The bench then expects `tx_bit` to carry the newly chosen level and `rx_bit` the sampled (or looped-back) level in the very next clock, each computed by its own bench function, with `ack_err` judged from the same sample.

// File: rtl/ack_slot_pkg.sv
package ack_slot_pkg;

  typedef enum logic [2:0] {
    FLD_IDLE      = 3'd0,
    FLD_BODY      = 3'd1,
    FLD_CRC_DELIM = 3'd2,
    FLD_ACK       = 3'd3,
    FLD_ACK_DELIM = 3'd4,
    FLD_EOF       = 3'd5
  } field_e;

  localparam logic DOM = 1'b0;
  localparam logic REC = 1'b1;

  // Level the node wants on the bus for the bit that starts now.
  function automatic logic drive_level(input field_e f, input logic tx_role,
                                       input logic crc_good, input logic forbid,
                                       input logic listen, input logic seq);
    logic lvl;
    lvl = REC;
    if (!listen) begin
      case (f)
        FLD_BODY: lvl = seq;
        FLD_ACK:  lvl = (!tx_role && crc_good && !forbid) ? DOM : REC;
        default:  lvl = REC;
      endcase
    end
    return lvl;
  endfunction

  // Internal loop-back acknowledge for a listen-only receiver.
  function automatic logic loop_ack(input field_e f, input logic tx_role,
                                    input logic crc_good, input logic listen);
    return listen && !tx_role && crc_good && (f == FLD_ACK);
  endfunction

  // Outcome of the acknowledge slot.
  function automatic logic slot_good(input logic tx_role, input logic bus_lvl,
                                     input logic self_test, input logic crc_good);
    return tx_role ? ((bus_lvl == DOM) || self_test) : crc_good;
  endfunction

  function automatic logic [63:0] count_step(input logic [63:0] v, input logic inc);
    return v + {63'd0, inc};
  endfunction

endpackage

// File: rtl/ack_bit_drive.sv
module ack_bit_drive
  import ack_slot_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  field_e fld,
  input  logic   sync_strobe,
  input  logic   sp_strobe,
  input  logic   bus_bit,
  input  logic   seq_bit,
  input  logic   is_tx,
  input  logic   crc_ok,
  input  logic   md_ack_forbid,
  input  logic   md_listen,
  output logic   tx_bit,
  output logic   rx_bit
);

  logic next_drive;
  logic loop_dom;

  always_comb begin
    next_drive = drive_level(fld, is_tx, crc_ok, md_ack_forbid, md_listen, seq_bit);
    loop_dom   = loop_ack(fld, is_tx, crc_ok, md_listen);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_bit <= REC;
    end else if (sync_strobe) begin
      tx_bit <= next_drive;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_bit <= REC;
    end else if (sp_strobe) begin
      rx_bit <= bus_bit & ~loop_dom;
    end
  end

  a_r2_hold_between_syncs: assert property (@(posedge clk) disable iff (rst)
    !sync_strobe |=> $stable(tx_bit));

  a_r4_forbid_recessive: assert property (@(posedge clk) disable iff (rst)
    (sync_strobe && md_ack_forbid && !is_tx && fld == FLD_ACK) |=> tx_bit);

  a_r5_listen_recessive: assert property (@(posedge clk) disable iff (rst)
    (sync_strobe && md_listen) |=> tx_bit);

  a_r6_listen_loopback: assert property (@(posedge clk) disable iff (rst)
    (sp_strobe && md_listen && !is_tx && crc_ok && fld == FLD_ACK) |=> !rx_bit);

  a_r6_plain_sample: assert property (@(posedge clk) disable iff (rst)
    (sp_strobe && fld != FLD_ACK) |=> (rx_bit == $past(bus_bit)));

endmodule

// File: rtl/ack_outcome.sv
module ack_outcome
  import ack_slot_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ack_sample,
  input  logic eof_entry,
  input  logic is_tx,
  input  logic bus_bit,
  input  logic crc_ok,
  input  logic md_self_test,
  output logic ack_err,
  output logic tx_good_evt,
  output logic rx_good_evt
);

  logic armed_q;
  logic good_q;
  logic role_tx_q;
  logic good_now;

  always_comb begin
    good_now    = slot_good(is_tx, bus_bit, md_self_test, crc_ok);
    tx_good_evt = eof_entry && armed_q && good_q && role_tx_q;
    rx_good_evt = eof_entry && armed_q && good_q && !role_tx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      good_q    <= 1'b0;
      role_tx_q <= 1'b0;
      ack_err   <= 1'b0;
    end else begin
      ack_err <= ack_sample && is_tx && !good_now;
      if (ack_sample) begin
        armed_q   <= 1'b1;
        good_q    <= good_now;
        role_tx_q <= is_tx;
      end else if (eof_entry) begin
        armed_q <= 1'b0;
      end
    end
  end

  a_r7_err_one_clock: assert property (@(posedge clk) disable iff (rst)
    ack_err |=> !ack_err);

  a_r8_selftest_no_err: assert property (@(posedge clk) disable iff (rst)
    (ack_sample && is_tx && md_self_test) |=> !ack_err);

  a_r7_err_not_counted: assert property (@(posedge clk) disable iff (rst)
    ack_err |-> !(armed_q && good_q));

endmodule

// File: rtl/frame_counters.sv
module frame_counters
  import ack_slot_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int NUM   = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM-1:0]             inc,
  output logic [NUM-1:0][CNT_W-1:0]  cnt
);

  localparam int PAD = 64 - CNT_W;

  for (genvar i = 0; i < NUM; i++) begin : g_cnt
    logic [63:0] wide_next;
    always_comb wide_next = count_step({{PAD{1'b0}}, cnt[i]}, inc[i]);

    always_ff @(posedge clk) begin
      if (rst) cnt[i] <= '0;
      else     cnt[i] <= wide_next[CNT_W-1:0];
    end

    a_r11_single_step: assert property (@(posedge clk) disable iff (rst)
      (cnt[i] != $past(cnt[i])) |-> (cnt[i] == $past(cnt[i]) + CNT_W'(1)));
  end

endmodule

// File: rtl/ack_slot_ctrl.sv
module ack_slot_ctrl
  import ack_slot_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       field,
  input  logic             sp_strobe,
  input  logic             sync_strobe,
  input  logic             bus_bit,
  input  logic             seq_bit,
  input  logic             is_tx,
  input  logic             crc_ok,
  input  logic             md_self_test,
  input  logic             md_ack_forbid,
  input  logic             md_listen,
  output logic             tx_bit,
  output logic             rx_bit,
  output logic             ack_err,
  output logic [CNT_W-1:0] tx_frames,
  output logic [CNT_W-1:0] rx_frames
);

  localparam int IDX_TX = 0;
  localparam int IDX_RX = 1;

  field_e fld;
  field_e fld_q;
  logic   ack_sample;
  logic   eof_entry;
  logic   tx_good_evt;
  logic   rx_good_evt;
  logic [1:0]            inc_vec;
  logic [1:0][CNT_W-1:0] cnt_vec;

  always_comb begin
    fld        = field_e'(field);
    ack_sample = sp_strobe && (fld == FLD_ACK);
    eof_entry  = (fld == FLD_EOF) && (fld_q != FLD_EOF);
    inc_vec[IDX_TX] = tx_good_evt;
    inc_vec[IDX_RX] = rx_good_evt;
    tx_frames  = cnt_vec[IDX_TX];
    rx_frames  = cnt_vec[IDX_RX];
  end

  always_ff @(posedge clk) begin
    if (rst) fld_q <= FLD_IDLE;
    else     fld_q <= fld;
  end

  ack_bit_drive u_drive (
    .clk           (clk),
    .rst           (rst),
    .fld           (fld),
    .sync_strobe   (sync_strobe),
    .sp_strobe     (sp_strobe),
    .bus_bit       (bus_bit),
    .seq_bit       (seq_bit),
    .is_tx         (is_tx),
    .crc_ok        (crc_ok),
    .md_ack_forbid (md_ack_forbid),
    .md_listen     (md_listen),
    .tx_bit        (tx_bit),
    .rx_bit        (rx_bit)
  );

  ack_outcome u_outcome (
    .clk          (clk),
    .rst          (rst),
    .ack_sample   (ack_sample),
    .eof_entry    (eof_entry),
    .is_tx        (is_tx),
    .bus_bit      (bus_bit),
    .crc_ok       (crc_ok),
    .md_self_test (md_self_test),
    .ack_err      (ack_err),
    .tx_good_evt  (tx_good_evt),
    .rx_good_evt  (rx_good_evt)
  );

  frame_counters #(.CNT_W(CNT_W), .NUM(2)) u_cnt (
    .clk (clk),
    .rst (rst),
    .inc (inc_vec),
    .cnt (cnt_vec)
  );

  a_r7_err_after_sample: assert property (@(posedge clk) disable iff (rst)
    ack_err |-> $past(ack_sample));

  a_r9_tx_only_at_eof: assert property (@(posedge clk) disable iff (rst)
    (tx_frames != $past(tx_frames)) |-> $past(eof_entry));

  a_r10_rx_only_at_eof: assert property (@(posedge clk) disable iff (rst)
    (rx_frames != $past(rx_frames)) |-> $past(eof_entry));

  a_r11_one_side_per_frame: assert property (@(posedge clk) disable iff (rst)
    !(tx_good_evt && rx_good_evt));

endmodule

// File: tb/ack_slot_ctrl_bench.sv
module ack_slot_ctrl_bench;

  localparam logic [2:0] F_IDLE = 3'd0, F_BODY = 3'd1, F_CDL = 3'd2,
                         F_ACK = 3'd3, F_ADL = 3'd4, F_EOF = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] field = F_IDLE;
  logic sp_strobe = 1'b0, sync_strobe = 1'b0, bus_bit = 1'b1, seq_bit = 1'b1;
  logic is_tx = 1'b0, crc_ok = 1'b0;
  logic md_self_test = 1'b0, md_ack_forbid = 1'b0, md_listen = 1'b0;
  logic tx_bit, rx_bit, ack_err;
  logic [31:0] tx_frames, rx_frames;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_tx_cnt = 0;
  logic [31:0] exp_rx_cnt = 0;
  logic prev_tx = 1'b1;

  always #4 clk = ~clk;

  ack_slot_ctrl u_ack_slot_ctrl (
    .clk(clk), .rst(rst), .field(field), .sp_strobe(sp_strobe),
    .sync_strobe(sync_strobe), .bus_bit(bus_bit), .seq_bit(seq_bit),
    .is_tx(is_tx), .crc_ok(crc_ok), .md_self_test(md_self_test),
    .md_ack_forbid(md_ack_forbid), .md_listen(md_listen),
    .tx_bit(tx_bit), .rx_bit(rx_bit), .ack_err(ack_err),
    .tx_frames(tx_frames), .rx_frames(rx_frames)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // Bench model: level to drive for a bit of field f.
  function automatic logic want_drive(input logic [2:0] f, input logic s);
    if (md_listen) return 1'b1;
    if (f == F_BODY) return s;
    if (f == F_ACK && !is_tx && crc_ok && !md_ack_forbid) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic want_rx(input logic [2:0] f, input logic b);
    if (f == F_ACK && md_listen && !is_tx && crc_ok) return 1'b0;
    return b;
  endfunction

  task automatic step(input logic [2:0] f, input logic s, input logic b,
                      input logic sy, input logic sp);
    field = f; seq_bit = s; bus_bit = b; sync_strobe = sy; sp_strobe = sp;
    @(negedge clk);
  endtask

  // One bit time: quiet, strobes (split or merged), quiet.
  task automatic bit_time(input logic [2:0] f, input logic s, input logic b,
                          input logic merge, input logic err_exp);
    step(f, s, b, 1'b0, 1'b0);
    chk("R2 hold", tx_bit, prev_tx);
    prev_tx = want_drive(f, s);
    if (merge) begin
      step(f, s, b, 1'b1, 1'b1);
      chk("R2/R3/R4/R5 drive", tx_bit, prev_tx);
      chk("R6 sample", rx_bit, want_rx(f, b));
      chk("R7/R8 ack_err", ack_err, err_exp);
    end else begin
      step(f, s, b, 1'b1, 1'b0);
      chk("R2/R3/R4/R5 drive", tx_bit, prev_tx);
      step(f, s, b, 1'b0, 1'b1);
      chk("R6 sample", rx_bit, want_rx(f, b));
      chk("R7/R8 ack_err", ack_err, err_exp);
    end
    step(f, s, b, 1'b0, 1'b0);
    chk("R7 one clock", ack_err, 1'b0);
  endtask

  task automatic frame(input logic tx, input logic crc, input logic st,
                       input logic af, input logic lom, input logic ack_dom,
                       input logic merge, input int nbody);
    logic ack_bus, good, err;
    is_tx = tx; crc_ok = crc; md_self_test = st; md_ack_forbid = af; md_listen = lom;
    for (int i = 0; i < nbody; i++) begin
      logic s;
      s = (i == nbody - 1) ? 1'b0 : 1'($urandom);
      bit_time(F_BODY, s, want_drive(F_BODY, s), merge, 1'b0);
    end
    bit_time(F_CDL, 1'b1, 1'b1, merge, 1'b0);
    ack_bus = tx ? ~ack_dom : want_drive(F_ACK, 1'b1);
    good    = tx ? (!ack_bus || st) : crc;
    err     = tx && !good;
    bit_time(F_ACK, 1'b1, ack_bus, merge, err);
    bit_time(F_ADL, 1'b1, 1'b1, merge, 1'b0);
    if (tx && good)  exp_tx_cnt++;
    if (!tx && good) exp_rx_cnt++;
    step(F_EOF, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R9 tx count at eof", tx_frames, exp_tx_cnt);
    chk("R10 rx count at eof", rx_frames, exp_rx_cnt);
    for (int k = 0; k < 3; k++) bit_time(F_EOF, 1'b1, 1'b1, merge, 1'b0);
    bit_time(F_IDLE, 1'b1, 1'b1, merge, 1'b0);
    chk("R11 tx once", tx_frames, exp_tx_cnt);
    chk("R11 rx once", rx_frames, exp_rx_cnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 tx_bit", tx_bit, 1'b1);
    chk("R1 rx_bit", rx_bit, 1'b1);
    chk("R1 ack_err", ack_err, 1'b0);
    chk("R1 tx_frames", tx_frames, 32'd0);
    chk("R1 rx_frames", rx_frames, 32'd0);
    rst = 1'b0;
    step(F_IDLE, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R1 after release", tx_frames | rx_frames, 32'd0);

    // Directed corners
    frame(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3); // R3 normal receiver
    frame(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3); // R4 forbid
    frame(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3); // R5/R6 listen-only
    frame(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3); // R10 bad crc
    frame(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3); // R7 missing ack
    frame(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3); // R8 self-test
    frame(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3); // R9 acked, merged strobes
    frame(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2); // R6 merged in listen-only

    // Constrained random frames
    for (int n = 0; n < 60; n++) begin
      logic tx, lom;
      tx  = 1'($urandom);
      lom = tx ? 1'b0 : 1'($urandom);
      frame(tx, 1'($urandom), 1'($urandom), 1'($urandom), lom,
            1'($urandom), 1'($urandom), 1 + int'($urandom % 6));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule